// File: doc/BRIEF.md
# Indexed-Opcode SPI Flash Cycle Sequencer

This block runs single command cycles against a serial flash device. Software first fills three tables: a menu of eight one-byte flash opcodes, two prefix opcodes (typically a write-enable style command), and a two-bit type per menu entry. The type bits say whether the opcode is followed by a 24-bit address and whether it is a write-class command. Software then starts a cycle with one control word. That word names a menu entry and a prefix entry by index and does not carry a raw opcode.

The sequencer drives a single chip select and SCK in SPI mode 0. It shifts out the opcode, then the address most significant byte first when the type calls for one, then an optional data phase of 1 to 64 bytes. Write-class opcodes send the contents of the data buffer. Every other opcode stores the bytes received on MISO into the buffer, starting at byte 0. In atomic mode the chosen prefix opcode goes out in its own chip-select frame before the main frame. A write-class opcode started without atomic mode is refused. Status flags report busy, done and refused. Software clears the done and refused flags by writing ones to them.

Top module: `opmenu_flash_seq`

## Requirements
- R1: After reset every host register and every buffer word reads zero, chip select is high (inactive) and SCK is low.
- R2: The host word addresses are: 0 control, 1 status, 2 address (bits 23:0), 3 type map, 4 prefix table (entry 0 in bits 7:0, entry 1 in bits 15:8), 5 SCK divider (bits 7:0), 6 and 7 opcode menu (entry n in word 6+n/4, byte n%4), 16 to 31 data buffer (byte 4w+b in word 16+w, bits 8b+7:8b). Each of these reads back what was last written while idle.
- R3: Writing the control word with bit 0 (go) set starts a cycle. Bits 5:3 pick the menu entry whose opcode is sent as the first byte of the frame. When the cycle ends, status bit 0 (busy) is low and status bit 1 (done) is set.
- R4: The 24-bit address follows the opcode, most significant byte first, exactly when type-map bit 2n is set for the selected entry n.
- R5: Control bit 6 enables a data phase of (bits 13:8)+1 bytes, from 1 to 64. When the entry is not write-class, byte k received on MISO lands in buffer byte k. With bit 6 clear the frame ends after the opcode or the address, and the buffer is left unchanged.
- R6: With control bit 1 (atomic) set, the prefix entry selected by control bit 2 goes out alone in one frame. Then chip select stays high for exactly one SCK period, and then the main frame follows.
- R7: When type-map bit 2n+1 marks entry n as write-class, the data phase sends buffer bytes 0 upward, and the buffer is left unchanged.
- R8: A write-class entry started without the atomic bit sends nothing on the serial pins, sets status bit 2 (refused) and leaves done clear.
- R9: While a cycle is busy, host writes to the control word and to every table, address, divider and buffer register are ignored. A second go does not start another cycle.
- R10: Status bits 1 and 2 clear only when 1 is written to them. Writing 0 leaves them set.
- R11: SCK idles low and stays low while chip select is high. MOSI changes only while SCK is low. One SCK period is 2*(divider+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| hWe | input | 1 | Host write strobe |
| hAddr | input | 5 | Host word address |
| hWrData | input | 32 | Host write data |
| hRdData | output | 32 | Host read data for hAddr, combinational |
| spiSck | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
A flash model in the bench logs every byte of every frame and returns a position-dependent byte pattern on MISO. The cycles tried are: an addressed read, an unaddressed read, an opcode-only command, atomic writes using both prefix entries, and a full 64-byte read. These show whether the address is inserted only for addressed entries, whether the data length follows the count field, and whether data direction follows the write-class bit. The bench measures the inter-frame chip-select gap and the SCK period, which shows whether the prefix frame is really separate and whether the divider works. A refused write, a second go issued while busy, and zero writes to status show that illegal or ill-timed requests leave the pins and registers untouched.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  localparam int MenuEntries   = 8;
  localparam int PrefixEntries = 2;
  localparam int BufBytes      = 64;
  localparam int AddrBytes     = 3;
  localparam int DivW          = 8;
  localparam int PtrW          = $clog2(MenuEntries);
  localparam int PreW          = $clog2(PrefixEntries);
  localparam int IdxW          = $clog2(BufBytes);
  localparam int BufWords      = BufBytes / 4;
  localparam int BufWordW      = $clog2(BufWords);
  localparam int HAddrW        = BufWordW + 1;
  localparam int MenuWords     = MenuEntries / 4;

  typedef enum logic [1:0] {
    SRC_PREFIX, SRC_OPCODE, SRC_ADDR, SRC_DATA
  } byteSrc_e;

  typedef struct packed {
    logic            busy;
    logic            load;
    byteSrc_e        src;
    logic [IdxW-1:0] idx;
    logic            sample;
    logic            shift;
    logic            store;
    logic [IdxW-1:0] wrIdx;
    logic            setDone;
    logic            setBlocked;
  } dpStrobe_t;

  typedef struct packed {
    logic            goReq;
    logic            atomic;
    logic            isWrite;
    logic            hasAddr;
    logic            dataEn;
    logic [IdxW-1:0] lastIdx;
    logic [DivW-1:0] div;
  } cmdView_t;
endpackage

// File: rtl/opseq_dp.sv
module opseq_dp
  import opseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hWe,
  input  logic [HAddrW-1:0] hAddr,
  input  logic [31:0]       hWrData,
  output logic [31:0]       hRdData,
  input  dpStrobe_t         stb,
  input  logic              miso,
  output logic              mosi,
  output cmdView_t          cmd,
  output logic [1:0]        flags
);
  localparam logic [HAddrW-1:0] ACtl   = HAddrW'(0);
  localparam logic [HAddrW-1:0] AStat  = HAddrW'(1);
  localparam logic [HAddrW-1:0] AAddr  = HAddrW'(2);
  localparam logic [HAddrW-1:0] AType  = HAddrW'(3);
  localparam logic [HAddrW-1:0] APre   = HAddrW'(4);
  localparam logic [HAddrW-1:0] ADiv   = HAddrW'(5);
  localparam logic [HAddrW-1:0] AMenu  = HAddrW'(6);
  localparam int CtlPreLsb = 2;
  localparam int CtlPtrLsb = CtlPreLsb + PreW;
  localparam int CtlDenBit = CtlPtrLsb + PtrW;
  localparam int CtlCntLsb = 8;

  logic [7:0]               menu   [MenuEntries];
  logic [7:0]               prefix [PrefixEntries];
  logic [7:0]               buffer [BufBytes];
  logic [2*MenuEntries-1:0] typeMap;
  logic [8*AddrBytes-1:0]   addrReg;
  logic [DivW-1:0]          divReg;
  logic                     ctlAtomic, ctlDataEn, goPend;
  logic [PreW-1:0]          ctlPre;
  logic [PtrW-1:0]          ctlPtr;
  logic [IdxW-1:0]          ctlCnt;
  logic                     doneFlag, blockedFlag;
  logic [7:0]               shReg, loadByte, rxByte;
  logic                     misoHold;
  logic                     cfgWe, isBuf;
  logic [BufWordW-1:0]      bufWord;

  assign cfgWe   = hWe && !stb.busy && !goPend;
  assign isBuf   = hAddr[HAddrW-1];
  assign bufWord = hAddr[BufWordW-1:0];
  assign rxByte  = {shReg[6:0], misoHold};
  assign mosi    = shReg[7];
  assign flags   = {blockedFlag, doneFlag};

  assign cmd.goReq   = goPend;
  assign cmd.atomic  = ctlAtomic;
  assign cmd.isWrite = typeMap[{ctlPtr, 1'b1}];
  assign cmd.hasAddr = typeMap[{ctlPtr, 1'b0}];
  assign cmd.dataEn  = ctlDataEn;
  assign cmd.lastIdx = ctlCnt;
  assign cmd.div     = divReg;

  // configuration and control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MenuEntries; i++) menu[i] <= '0;
      for (int i = 0; i < PrefixEntries; i++) prefix[i] <= '0;
      typeMap   <= '0;
      addrReg   <= '0;
      divReg    <= '0;
      ctlAtomic <= 1'b0;
      ctlDataEn <= 1'b0;
      ctlPre    <= '0;
      ctlPtr    <= '0;
      ctlCnt    <= '0;
      goPend    <= 1'b0;
    end else begin
      goPend <= 1'b0;
      if (cfgWe && !isBuf) begin
        unique case (hAddr)
          ACtl: begin
            ctlAtomic <= hWrData[1];
            ctlPre    <= hWrData[CtlPreLsb +: PreW];
            ctlPtr    <= hWrData[CtlPtrLsb +: PtrW];
            ctlDataEn <= hWrData[CtlDenBit];
            ctlCnt    <= hWrData[CtlCntLsb +: IdxW];
            goPend    <= hWrData[0];
          end
          AAddr: addrReg <= hWrData[8*AddrBytes-1:0];
          AType: typeMap <= hWrData[2*MenuEntries-1:0];
          APre:  for (int i = 0; i < PrefixEntries; i++) prefix[i] <= hWrData[8*i +: 8];
          ADiv:  divReg  <= hWrData[DivW-1:0];
          default: begin
            for (int w = 0; w < MenuWords; w++)
              if (hAddr == AMenu + HAddrW'(w))
                for (int b = 0; b < 4; b++) menu[4*w+b] <= hWrData[8*b +: 8];
          end
        endcase
      end
    end
  end

  // status flags: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag    <= 1'b0;
      blockedFlag <= 1'b0;
    end else begin
      if (stb.setDone) doneFlag <= 1'b1;
      else if (hWe && hAddr == AStat && hWrData[1]) doneFlag <= 1'b0;
      if (stb.setBlocked) blockedFlag <= 1'b1;
      else if (hWe && hAddr == AStat && hWrData[2]) blockedFlag <= 1'b0;
    end
  end

  // data buffer: host side when idle, serial capture when busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BufBytes; i++) buffer[i] <= '0;
    end else if (stb.store) begin
      buffer[stb.wrIdx] <= rxByte;
    end else if (cfgWe && isBuf) begin
      for (int b = 0; b < 4; b++) buffer[{bufWord, 2'(b)}] <= hWrData[8*b +: 8];
    end
  end

  always_comb begin
    loadByte = 8'h00;
    unique case (stb.src)
      SRC_PREFIX: loadByte = prefix[ctlPre];
      SRC_OPCODE: loadByte = menu[ctlPtr];
      SRC_ADDR: begin
        for (int b = 0; b < AddrBytes; b++)
          if (stb.idx == IdxW'(b)) loadByte = addrReg[8*(AddrBytes-1-b) +: 8];
      end
      SRC_DATA: loadByte = cmd.isWrite ? buffer[stb.idx] : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      misoHold <= 1'b0;
    end else begin
      if (stb.sample) misoHold <= miso;
      if (stb.load) shReg <= loadByte;
      else if (stb.shift) shReg <= rxByte;
    end
  end

  always_comb begin
    hRdData = '0;
    if (isBuf) begin
      for (int b = 0; b < 4; b++) hRdData[8*b +: 8] = buffer[{bufWord, 2'(b)}];
    end else begin
      unique case (hAddr)
        ACtl: begin
          hRdData[1]                    = ctlAtomic;
          hRdData[CtlPreLsb +: PreW]    = ctlPre;
          hRdData[CtlPtrLsb +: PtrW]    = ctlPtr;
          hRdData[CtlDenBit]            = ctlDataEn;
          hRdData[CtlCntLsb +: IdxW]    = ctlCnt;
        end
        AStat: hRdData[2:0] = {blockedFlag, doneFlag, stb.busy};
        AAddr: hRdData[8*AddrBytes-1:0] = addrReg;
        AType: hRdData[2*MenuEntries-1:0] = typeMap;
        APre:  for (int i = 0; i < PrefixEntries; i++) hRdData[8*i +: 8] = prefix[i];
        ADiv:  hRdData[DivW-1:0] = divReg;
        default: begin
          for (int w = 0; w < MenuWords; w++)
            if (hAddr == AMenu + HAddrW'(w))
              for (int b = 0; b < 4; b++) hRdData[8*b +: 8] = menu[4*w+b];
        end
      endcase
    end
  end
endmodule

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  cmdView_t  cmd,
  output dpStrobe_t stb,
  output logic      sck,
  output logic      csN
);
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_HOLD, ST_GAP} state_e;

  state_e          state, nState;
  byteSrc_e        seg, nSeg;
  logic            phase, nPhase, gapCnt, nGap, mainNext, nMain, nSck, nCs;
  logic [2:0]      bitCnt, nBit;
  logic [IdxW-1:0] byteIdx, nIdx;
  logic [DivW-1:0] divCnt;
  logic            tick, doLoad;

  assign tick = (state != ST_IDLE) && (divCnt == cmd.div);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (state == ST_IDLE || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    stb            = '0;
    stb.busy       = (state != ST_IDLE);
    stb.wrIdx      = byteIdx;
    nState = state; nSeg = seg; nPhase = phase; nBit = bitCnt; nIdx = byteIdx;
    nGap = gapCnt; nMain = mainNext; nSck = sck; nCs = csN;
    doLoad = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmd.goReq) begin
          if (cmd.isWrite && !cmd.atomic) begin
            stb.setBlocked = 1'b1;
          end else begin
            nState = ST_XFER; nCs = 1'b0; nPhase = 1'b0; nBit = '0; nIdx = '0;
            nMain  = cmd.atomic;
            nSeg   = cmd.atomic ? SRC_PREFIX : SRC_OPCODE;
            doLoad = 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (tick) begin
          if (!phase) begin
            nSck = 1'b1; nPhase = 1'b1; stb.sample = 1'b1;
          end else begin
            nSck = 1'b0; nPhase = 1'b0; stb.shift = 1'b1;
            if (bitCnt != 3'd7) begin
              nBit = bitCnt + 3'd1;
            end else begin
              nBit = '0;
              stb.store = (seg == SRC_DATA) && !cmd.isWrite;
              unique case (seg)
                SRC_PREFIX: nState = ST_HOLD;
                SRC_OPCODE: begin
                  if (cmd.hasAddr) begin
                    nSeg = SRC_ADDR; nIdx = '0; doLoad = 1'b1;
                  end else if (cmd.dataEn) begin
                    nSeg = SRC_DATA; nIdx = '0; doLoad = 1'b1;
                  end else nState = ST_HOLD;
                end
                SRC_ADDR: begin
                  if (byteIdx != IdxW'(AddrBytes-1)) begin
                    nIdx = byteIdx + 1'b1; doLoad = 1'b1;
                  end else if (cmd.dataEn) begin
                    nSeg = SRC_DATA; nIdx = '0; doLoad = 1'b1;
                  end else nState = ST_HOLD;
                end
                SRC_DATA: begin
                  if (byteIdx != cmd.lastIdx) begin
                    nIdx = byteIdx + 1'b1; doLoad = 1'b1;
                  end else nState = ST_HOLD;
                end
              endcase
            end
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          nCs = 1'b1; nState = ST_GAP; nGap = 1'b0;
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (!gapCnt) begin
            nGap = 1'b1;
          end else if (mainNext) begin
            nMain = 1'b0; nSeg = SRC_OPCODE; nState = ST_XFER; nCs = 1'b0;
            nPhase = 1'b0; nBit = '0; nIdx = '0; doLoad = 1'b1;
          end else begin
            nState = ST_IDLE; stb.setDone = 1'b1;
          end
        end
      end
    endcase
    if (doLoad) begin
      stb.load = 1'b1;
      stb.src  = nSeg;
      stb.idx  = nIdx;
    end else begin
      stb.src  = seg;
      stb.idx  = byteIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; seg <= SRC_OPCODE; phase <= 1'b0; bitCnt <= '0;
      byteIdx <= '0; gapCnt <= 1'b0; mainNext <= 1'b0; sck <= 1'b0; csN <= 1'b1;
    end else begin
      state <= nState; seg <= nSeg; phase <= nPhase; bitCnt <= nBit;
      byteIdx <= nIdx; gapCnt <= nGap; mainNext <= nMain; sck <= nSck; csN <= nCs;
    end
  end
endmodule

// File: rtl/opmenu_flash_seq.sv
module opmenu_flash_seq
  import opseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hWe,
  input  logic [HAddrW-1:0] hAddr,
  input  logic [31:0]       hWrData,
  output logic [31:0]       hRdData,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);
  dpStrobe_t  stbBus;
  cmdView_t   cmdBus;
  logic [1:0] statFlags;

  opseq_dp u_dp (
    .clk(clk), .rstN(rstN), .hWe(hWe), .hAddr(hAddr), .hWrData(hWrData),
    .hRdData(hRdData), .stb(stbBus), .miso(spiMiso), .mosi(spiMosi),
    .cmd(cmdBus), .flags(statFlags)
  );

  opseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmdBus), .stb(stbBus), .sck(spiSck), .csN(spiCsN)
  );
endmodule

// File: rtl/opmenu_flash_seq_chk.sv
module opmenu_flash_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sck,
  input logic       csN,
  input logic       mosi,
  input logic       busy,
  input logic [1:0] flags
);
  p_sck_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
  p_mosi_steady_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi));
  p_cs_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);
  p_done_at_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> flags[0]);
  p_refuse_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> (csN && !busy));
endmodule

bind opmenu_flash_seq opmenu_flash_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .sck(spiSck), .csN(spiCsN), .mosi(spiMosi),
  .busy(stbBus.busy), .flags(statFlags)
);

// File: tb/tb_opmenu_flash_seq.sv
module tb_opmenu_flash_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hWe = 1'b0;
  logic [4:0]  hAddr = '0;
  logic [31:0] hWrData = '0;
  logic [31:0] hRdData;
  logic        spiSck, spiCsN, spiMosi, spiMiso;

  int testCnt = 0, failCnt = 0, cyc = 0;

  opmenu_flash_seq dut (
    .clk(clk), .rstN(rstN), .hWe(hWe), .hAddr(hAddr), .hWrData(hWrData),
    .hRdData(hRdData), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 91) & 255);
  endfunction

  // flash model: logs every byte of every frame, returns pat(k) on MISO
  logic [7:0] logB [0:3][0:79];
  int frameLen [0:3];
  int frameCnt = 0, bitIn = 0, byteIn = 0;
  logic [7:0] rxShift = '0, patCur;
  assign patCur  = pat(byteIn);
  assign spiMiso = !spiCsN && patCur[3'(7 - bitIn)];

  always @(negedge spiCsN) begin bitIn = 0; byteIn = 0; end
  always @(posedge spiSck) if (!spiCsN) begin
    rxShift = {rxShift[6:0], spiMosi};
    bitIn++;
    if (bitIn == 8) begin
      if (frameCnt < 4 && byteIn < 80) logB[frameCnt][byteIn] = rxShift;
      bitIn = 0; byteIn++;
      if (frameCnt < 4) frameLen[frameCnt] = byteIn;
    end
  end
  always @(posedge spiCsN) if (rstN) frameCnt++;

  // chip-select gap and SCK period monitors
  int highRun = 0, lastGap = 0, lastRise = 0, lastPer = 0;
  bit sawFrame = 0;
  always @(posedge clk) begin
    cyc++;
    if (spiCsN) highRun++;
    else begin
      if (highRun > 0 && sawFrame) lastGap = highRun;
      highRun = 0; sawFrame = 1;
    end
    if (cyc == 150000) begin
      failCnt++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
  always @(posedge spiSck) begin lastPer = cyc - lastRise; lastRise = cyc; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); hAddr = 5'(a); hWrData = d; hWe = 1'b1;
    @(negedge clk); hWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); hAddr = 5'(a); #1; d = hRdData;
  endtask

  function automatic logic [31:0] mkCtl(bit go, bit atomic, bit pre, int ptr, bit den, int cnt);
    return {18'd0, 6'(cnt), 1'b0, den, 3'(ptr), pre, atomic, go};
  endfunction

  task automatic clearLog();
    frameCnt = 0; sawFrame = 0; lastGap = 0;
    for (int i = 0; i < 4; i++) frameLen[i] = 0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 40000; i++) begin
      rd(1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic setupTables(input int div);
    wr(6, 32'h9F05_0B03);
    wr(7, 32'h01D8_2002);
    wr(4, 32'h0000_0650);
    wr(3, 32'h0000_BF05);
    wr(5, div);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin rd(a, v); chk($sformatf("R1 reg %0d", a), v, 0); end
    rd(16, v); chk("R1 buffer word 0", v, 0);
    rd(31, v); chk("R1 buffer word 15", v, 0);
    chk("R1 csN idle", spiCsN, 1);
    chk("R1 sck idle", spiSck, 0);
  endtask

  task automatic test_regs();
    logic [31:0] v;
    wr(2, 32'hFF12_3456); rd(2, v); chk("R2 address", v, 32'h0012_3456);
    wr(3, 32'h1234_ABCD); rd(3, v); chk("R2 type map", v, 32'h0000_ABCD);
    wr(4, 32'hAAAA_0650); rd(4, v); chk("R2 prefix table", v, 32'h0000_0650);
    wr(5, 32'h0000_0107); rd(5, v); chk("R2 divider", v, 32'h0000_0007);
    wr(6, 32'h1122_3344); rd(6, v); chk("R2 menu low", v, 32'h1122_3344);
    wr(7, 32'h5566_7788); rd(7, v); chk("R2 menu high", v, 32'h5566_7788);
    wr(20, 32'hCAFE_F00D); rd(20, v); chk("R2 buffer word 4", v, 32'hCAFE_F00D);
    wr(20, 0);
  endtask

  task automatic test_read_addr();
    logic [31:0] v;
    setupTables(1); clearLog();
    wr(2, 32'h0012_3456);
    wr(0, mkCtl(1, 0, 0, 0, 1, 3));
    waitIdle();
    chk("R3 frame count", frameCnt, 1);
    chk("R5 frame length", frameLen[0], 8);
    chk("R3 opcode", logB[0][0], 8'h03);
    chk("R4 addr msb", logB[0][1], 8'h12);
    chk("R4 addr mid", logB[0][2], 8'h34);
    chk("R4 addr lsb", logB[0][3], 8'h56);
    rd(16, v); chk("R5 captured bytes 0-3", v, {pat(7), pat(6), pat(5), pat(4)});
    rd(1, v); chk("R3 status done, not busy", v, 32'h2);
  endtask

  task automatic test_noaddr();
    logic [31:0] v;
    wr(1, 32'h2); clearLog();
    wr(0, mkCtl(1, 0, 0, 3, 1, 2));
    waitIdle();
    chk("R4 no address length", frameLen[0], 4);
    chk("R4 unaddressed opcode", logB[0][0], 8'h9F);
    rd(16, v); chk("R5 capture from byte 0", v, {pat(7), pat(3), pat(2), pat(1)});
  endtask

  task automatic test_opcode_only();
    logic [31:0] v;
    wr(1, 32'h2); clearLog();
    wr(0, mkCtl(1, 0, 0, 2, 0, 5));
    waitIdle();
    chk("R5 opcode-only length", frameLen[0], 1);
    chk("R3 opcode entry 2", logB[0][0], 8'h05);
    rd(16, v); chk("R5 buffer untouched", v, {pat(7), pat(3), pat(2), pat(1)});
    rd(1, v); chk("R3 done after short frame", v, 32'h2);
  endtask

  task automatic test_atomic_write();
    logic [31:0] v;
    wr(1, 32'h2); clearLog();
    wr(16, 32'h4433_2211); wr(17, 32'h0000_0055);
    wr(2, 32'h000A_0B0C);
    wr(0, mkCtl(1, 1, 1, 4, 1, 4));
    waitIdle();
    chk("R6 two frames", frameCnt, 2);
    chk("R6 prefix frame length", frameLen[0], 1);
    chk("R6 prefix entry 1", logB[0][0], 8'h06);
    chk("R6 gap one SCK period", lastGap, 4);
    chk("R7 main length", frameLen[1], 9);
    chk("R7 program opcode", logB[1][0], 8'h02);
    chk("R4 write addr msb", logB[1][1], 8'h0A);
    chk("R7 data byte 0", logB[1][4], 8'h11);
    chk("R7 data byte 4", logB[1][8], 8'h55);
    rd(16, v); chk("R7 buffer kept", v, 32'h4433_2211);
    wr(1, 32'h2); clearLog();
    wr(0, mkCtl(1, 1, 0, 7, 1, 0));
    waitIdle();
    chk("R6 prefix entry 0", logB[0][0], 8'h50);
    chk("R7 write-status frame", {logB[1][0], logB[1][1]}, 16'h0111);
  endtask

  task automatic test_blocked();
    logic [31:0] v;
    wr(1, 32'h6); clearLog();
    wr(0, mkCtl(1, 0, 0, 5, 0, 0));
    repeat (20) @(negedge clk);
    chk("R8 no frame", frameCnt + int'(sawFrame), 0);
    rd(1, v); chk("R8 refused flag only", v, 32'h4);
    wr(1, 32'h0); rd(1, v); chk("R10 zero write keeps refused", v, 32'h4);
    wr(1, 32'h4); rd(1, v); chk("R10 refused cleared", v, 32'h0);
  endtask

  task automatic test_busy_ignore();
    logic [31:0] v;
    wr(5, 7); wr(2, 32'h0000_0100); clearLog();
    wr(0, mkCtl(1, 0, 0, 1, 1, 63));
    repeat (10) @(negedge clk);
    rd(1, v); chk("R9 busy seen", v[0], 1);
    wr(0, mkCtl(1, 0, 0, 3, 0, 0));
    wr(2, 32'h00FF_FFFF);
    wr(5, 0);
    rd(0, v); chk("R9 control kept", v, mkCtl(0, 0, 0, 1, 1, 63));
    rd(2, v); chk("R9 address kept", v, 32'h0000_0100);
    rd(5, v); chk("R9 divider kept", v, 7);
    waitIdle();
    repeat (40) @(negedge clk);
    chk("R9 single frame", frameCnt, 1);
    chk("R5 64-byte frame length", frameLen[0], 68);
    chk("R3 opcode entry 1", logB[0][0], 8'h0B);
    rd(31, v); chk("R5 last buffer byte", v[31:24], pat(67));
  endtask

  task automatic test_w1c_timing();
    logic [31:0] v;
    rd(1, v); chk("R10 done still set", v, 32'h2);
    wr(1, 32'h0); rd(1, v); chk("R10 zero write keeps done", v, 32'h2);
    wr(1, 32'h2); rd(1, v); chk("R10 done cleared", v, 32'h0);
    wr(5, 3); clearLog();
    wr(0, mkCtl(1, 0, 0, 2, 0, 0));
    waitIdle();
    chk("R11 SCK period div 3", lastPer, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_regs();
    test_read_addr();
    test_noaddr();
    test_opcode_only();
    test_atomic_write();
    test_blocked();
    test_busy_ignore();
    test_w1c_timing();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule